// File: doc/BRIEF.md
# Interrupting Port Number Queue

This block keeps a short first-in, first-out record of which bus ports have asked for service. The bus sequencer pulses a completion strobe each time it leaves its idle/dispatch state for a port, and the number of that port is written into the queue. The host sees a single interrupt line that is high while at least one port number is waiting.

The host services the interrupt by reading one status register. The read strobe removes the oldest entry, and the value on the status read port during that strobe is the port number being removed. A full flag shows when every slot is occupied. A sticky overflow flag records that a port number was lost because the queue was full. A channel initialise command empties the queue and clears every flag.

The queue is three entries deep and a port number is four bits wide by default. Both values are parameters.

Top module: `port_irq_fifo`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first sample after it, `irq`, `full` and `overflow` are 0 and `stat_port` reads 0.
- R2: A `seq_done` pulse stores `seq_port` in the queue. If the queue was empty, `irq` is 1 from the clock edge that samples the pulse.
- R3: The queue holds `DEPTH` (default 3) entries. `full` is 1 exactly when all of them are occupied.
- R4: Entries leave in arrival order. During a `stat_rd` strobe, `stat_port` shows the oldest stored port number, and the clock edge that samples the strobe removes that entry.
- R5: After a read, `irq` stays 1 if any entry remains. It falls at the edge that removes the last entry.
- R6: A `stat_rd` strobe while the queue is empty has no effect on the queue contents or on any output.
- R7: A `seq_done` pulse while the queue is full, with no read in the same cycle, is dropped. The stored entries do not change, and `overflow` becomes 1 and stays 1 until an initialise.
- R8: When `seq_done` and `stat_rd` occur in the same cycle on a non-empty queue, both take effect: the entry count is unchanged and order is kept. This also holds when the queue is full. On an empty queue, only the push takes effect.
- R9: `chan_init` takes priority over a push or read in the same cycle. From the next edge, the queue is empty and `irq`, `full` and `overflow` are 0.
- R10: While the queue is empty, `stat_port` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_init | input | 1 | Channel initialise: empty the queue and clear the flags |
| seq_done | input | 1 | Sequencer finished its dispatch state for a port: push |
| seq_port | input | PORT_W | Number of the port that raised the interrupt |
| stat_rd | input | 1 | Status register read strobe: pop the oldest entry |
| stat_port | output | PORT_W | Oldest port number, or 0 when the queue is empty |
| irq | output | 1 | Interrupt request, high while any entry is pending |
| full | output | 1 | All entries occupied |
| overflow | output | 1 | Sticky flag: a push was lost while the queue was full |

## Verification
The assertions assume that `chan_init`, `seq_done` and `stat_rd` carry known values at every clock edge. Each cycle with a strobe high counts as one request. `seq_port` needs to be valid only in cycles where `seq_done` is high. The bench changes all inputs half a period away from the active edge and always with defined values. It mixes random push, read and initialise rates with directed sequences that fill the queue, overfill it, drain it, read it while empty, and combine a push with a read at the empty and the full level.

// File: rtl/port_irq_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupting port number queue.
package port_irq_fifo_pkg;

    // Kind of queue update accepted in one cycle: {push accepted, pop accepted}
    typedef enum logic [1:0] {
        QOP_NONE = 2'b00,
        QOP_POP  = 2'b01,
        QOP_PUSH = 2'b10,
        QOP_BOTH = 2'b11
    } qop_e;

endpackage

// File: rtl/port_irq_fifo_ctrl.sv
`timescale 1ns/1ps
// Queue controller: decides which push and pop requests are accepted, keeps
// the write and read slot indices and the occupancy count, and holds the
// sticky overflow flag.
// Assumes: requests are sampled on every rising edge. Initialise has
// priority over both requests. A pop frees a slot for a push in the same cycle.
module port_irq_fifo_ctrl
    import port_irq_fifo_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] occ,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] OCC_MAX  = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic pop_ok;
    logic push_ok;
    logic drop;
    qop_e op;

    // Advance a slot index, wrapping at the configured depth
    function automatic logic [PTR_W-1:0] step_idx(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    // Decide which of this cycle's requests are accepted
    always_comb begin
        pop_ok  = pop_req && (occ != '0);
        push_ok = push_req && ((occ != OCC_MAX) || pop_ok);
        drop    = push_req && !push_ok;
        op      = qop_e'({push_ok, pop_ok});
        wr_en   = push_ok && !init;
    end

    // Slot indices and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            wr_idx <= '0;
            rd_idx <= '0;
            occ    <= '0;
        end else begin
            case (op)
                QOP_PUSH: begin
                    wr_idx <= step_idx(wr_idx);
                    occ    <= occ + CNT_W'(1);
                end
                QOP_POP: begin
                    rd_idx <= step_idx(rd_idx);
                    occ    <= occ - CNT_W'(1);
                end
                QOP_BOTH: begin
                    wr_idx <= step_idx(wr_idx);
                    rd_idx <= step_idx(rd_idx);
                end
                default: ;
            endcase
        end
    end

    // Sticky overflow flag, set by a dropped push
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            ovf <= 1'b0;
        end else if (drop) begin
            ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/port_irq_fifo_store.sv
`timescale 1ns/1ps
// Entry storage: DEPTH registers of PORT_W bits. It has one write port
// addressed by slot index and a read port selected by slot index.
// Assumes: indices stay below DEPTH, which the controller guarantees.
module port_irq_fifo_store #(
    parameter int DEPTH  = 3,
    parameter int PORT_W = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [PORT_W-1:0] rd_data
);

    logic [PORT_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // One entry register, loaded when the write index selects it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (wr_en && (wr_idx == PTR_W'(i))) begin
                slot[i] <= wr_data;
            end
        end
    end

    // Read selection by comparison, so no out-of-range index is formed
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PTR_W'(i)) begin
                rd_data = slot[i];
            end
        end
    end

endmodule

// File: rtl/port_irq_fifo_status.sv
`timescale 1ns/1ps
// Status outputs: interrupt request and full flag from the occupancy count,
// and the read value, forced to zero while the queue is empty.
// Assumes: occ never exceeds DEPTH.
module port_irq_fifo_status #(
    parameter int DEPTH  = 3,
    parameter int PORT_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  occ,
    input  logic [PORT_W-1:0] head,
    output logic              irq,
    output logic              full,
    output logic [PORT_W-1:0] port_out
);

    // Derive the host-visible flags and read value
    always_comb begin
        irq      = (occ != '0);
        full     = (occ == CNT_W'(DEPTH));
        port_out = irq ? head : '0;
    end

endmodule

// File: rtl/port_irq_fifo.sv
`timescale 1ns/1ps
// Interrupting port number queue, top level. It records the numbers of
// ports whose sequencer dispatch has finished, raises an interrupt while any
// number is pending, and releases the oldest number on each status read.
// Assumes: single clock, synchronous active-low reset, and strobes that
// count once per cycle they are high.
module port_irq_fifo #(
    parameter int DEPTH  = 3,
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_init,
    input  logic              seq_done,
    input  logic [PORT_W-1:0] seq_port,
    input  logic              stat_rd,
    output logic [PORT_W-1:0] stat_port,
    output logic              irq,
    output logic              full,
    output logic              overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [CNT_W-1:0] occ;
    logic [PORT_W-1:0] head;

    port_irq_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (chan_init),
        .push_req (seq_done),
        .pop_req  (stat_rd),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .occ      (occ),
        .ovf      (overflow)
    );

    port_irq_fifo_store #(.DEPTH(DEPTH), .PORT_W(PORT_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (seq_port),
        .rd_idx  (rd_idx),
        .rd_data (head)
    );

    port_irq_fifo_status #(.DEPTH(DEPTH), .PORT_W(PORT_W)) status_i (
        .occ      (occ),
        .head     (head),
        .irq      (irq),
        .full     (full),
        .port_out (stat_port)
    );

endmodule

// File: rtl/port_irq_fifo_chk.sv
`timescale 1ns/1ps
// Assertion checker for the interrupting port number queue, bound to the top.
module port_irq_fifo_chk #(
    parameter int DEPTH  = 3,
    parameter int PORT_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chan_init,
    input logic              seq_done,
    input logic              stat_rd,
    input logic [PORT_W-1:0] stat_port,
    input logic              irq,
    input logic              full,
    input logic              overflow,
    input logic [CNT_W-1:0]  occ
);

    // R9: initialise empties the queue and clears every flag
    a_r9_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chan_init |=> (!irq && !full && !overflow && occ == '0));

    // R2: an accepted push raises the interrupt at the next edge
    a_r2_push_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !chan_init) |=> irq);

    // R3: the last free slot filled by a push gives full
    a_r3_fill_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !stat_rd && !chan_init && occ == CNT_W'(DEPTH - 1)) |=> full);

    // R5: interrupt stays while entries remain after a read
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !chan_init && occ > CNT_W'(1)) |=> irq);

    // R5: interrupt drops when the last entry leaves
    a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !seq_done && !chan_init && occ == CNT_W'(1)) |=> !irq);

    // R6: a read of an empty queue changes nothing
    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !seq_done && !chan_init && !irq) |=> (!irq && $stable(occ)));

    // R7: a dropped push sets the overflow flag
    a_r7_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && full && !stat_rd && !chan_init) |=> overflow);

    // R7: overflow is sticky until initialise
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !chan_init) |=> overflow);

    // R8: push with read on a non-empty queue keeps the count
    a_r8_both_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && stat_rd && irq && !chan_init) |=> $stable(occ));

    // R4: the oldest entry holds still until it is read
    a_r4_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_rd && !chan_init) |=> $stable(stat_port));

endmodule

bind port_irq_fifo port_irq_fifo_chk #(.DEPTH(DEPTH), .PORT_W(PORT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_init (chan_init),
    .seq_done  (seq_done),
    .stat_rd   (stat_rd),
    .stat_port (stat_port),
    .irq       (irq),
    .full      (full),
    .overflow  (overflow),
    .occ       (occ)
);

// File: tb/port_irq_fifo_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random traffic.
module port_irq_fifo_tb_top;

    localparam int DEPTH  = 3;
    localparam int PORT_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chan_init = 1'b0;
    logic              seq_done = 1'b0;
    logic [PORT_W-1:0] seq_port = '0;
    logic              stat_rd = 1'b0;
    logic [PORT_W-1:0] stat_port;
    logic              irq;
    logic              full;
    logic              overflow;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    int model_q[$];
    bit model_ovf = 0;

    always #2.5 clk = ~clk;

    port_irq_fifo #(.DEPTH(DEPTH), .PORT_W(PORT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .chan_init(chan_init), .seq_done(seq_done),
        .seq_port(seq_port), .stat_rd(stat_rd), .stat_port(stat_port),
        .irq(irq), .full(full), .overflow(overflow)
    );

    function automatic int exp_head();
        return (model_q.size() > 0) ? model_q[0] : 0;
    endfunction

    function automatic bit exp_irq();
        return model_q.size() > 0;
    endfunction

    function automatic bit exp_full();
        return model_q.size() == DEPTH;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare every output with the model
    task automatic chk_all();
        chk("R5", "irq", int'(irq), int'(exp_irq()));
        chk("R3", "full", int'(full), int'(exp_full()));
        chk("R7", "overflow", int'(overflow), int'(model_ovf));
        chk("R4", "stat_port", int'(stat_port), exp_head());
    endtask

    // Apply one cycle of stimulus (called at a falling edge), update the
    // model at the rising edge, and check at the next falling edge
    task automatic cyc(input bit init, input bit push, input int port, input bit pop);
        bit popped;
        chan_init = init;
        seq_done  = push;
        seq_port  = PORT_W'(port);
        stat_rd   = pop;
        #1;
        if (pop && !init) chk("R4", "read value during strobe", int'(stat_port), exp_head());
        @(posedge clk);
        if (init) begin
            model_q.delete();
            model_ovf = 0;
        end else begin
            popped = pop && (model_q.size() > 0);
            if (popped) void'(model_q.pop_front());
            if (push) begin
                if (model_q.size() < DEPTH) model_q.push_back(port);
                else model_ovf = 1;
            end
        end
        @(negedge clk);
        chan_init = 0; seq_done = 0; stat_rd = 0;
        chk_all();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1", "irq in reset", int'(irq), 0);
        chk("R1", "full in reset", int'(full), 0);
        chk("R1", "overflow in reset", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "stat_port after reset", int'(stat_port), 0);

        // R6: read on an empty queue has no effect
        cyc(0, 0, 0, 1);
        chk("R6", "irq after empty read", int'(irq), 0);

        // R2: first push raises the interrupt
        cyc(0, 1, 5, 0);
        chk("R2", "irq after push", int'(irq), 1);
        cyc(0, 1, 9, 0);
        cyc(0, 1, 3, 0);
        chk("R3", "full at three", int'(full), 1);

        // R7: push while full is dropped
        cyc(0, 1, 12, 0);
        chk("R7", "overflow set", int'(overflow), 1);
        chk("R7", "head unchanged", int'(stat_port), 5);

        // R8: push with read while full
        cyc(0, 1, 14, 1);
        chk("R8", "full kept", int'(full), 1);
        chk("R8", "new head", int'(stat_port), 9);

        // R4 / R5: drain in order
        cyc(0, 0, 0, 1);
        chk("R4", "order head", int'(stat_port), 3);
        cyc(0, 0, 0, 1);
        chk("R5", "irq with one left", int'(irq), 1);
        chk("R4", "last head", int'(stat_port), 14);
        cyc(0, 0, 0, 1);
        chk("R5", "irq after last read", int'(irq), 0);
        chk("R10", "stat_port empty", int'(stat_port), 0);
        chk("R7", "overflow still sticky", int'(overflow), 1);

        // R8: push with read on an empty queue keeps only the push
        cyc(0, 1, 6, 1);
        chk("R8", "push kept on empty", int'(stat_port), 6);

        // R9: initialise wins over same-cycle push and read
        cyc(0, 1, 7, 0);
        cyc(1, 1, 8, 1);
        chk("R9", "irq after init", int'(irq), 0);
        chk("R9", "overflow after init", int'(overflow), 0);
        chk("R10", "stat_port after init", int'(stat_port), 0);

        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            bit i_b = ($urandom_range(99) < 2);
            bit p_b = ($urandom_range(99) < 45);
            bit r_b = ($urandom_range(99) < 38);
            cyc(i_b, p_b, int'($urandom_range(15)), r_b);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule